// File: doc/BRIEF.md
# Auto-reload single-channel DMA mover

This block is one DMA channel that copies a single 8-bit or 16-bit unit over a simple memory bus each time a request arrives. A request comes either from a software request bit or from a hardware request pulse, depending on a trigger-select input. The channel holds a working transfer counter and a working forward address pointer. It reads one unit from the source side of the bus and writes it to the destination side. It then steps its counter and pointer and hands the bus back.

The channel runs in repeat mode. When the counter wraps below zero, the channel raises its interrupt flag and stays enabled. It then marks itself so that the next request reloads the counter from the reload value and reloads the forward pointer from its base address before it moves data. The base address comes from the source address or the destination address, depending on the address mode.

The configuration values (addresses, reload count, address mode, unit size, trigger select and enable) come from outside as plain inputs held by the surrounding register logic. The CPU acknowledges the interrupt through a strobe input.

Top module: `dmarep_chan`

## Requirements
- R1: With the trigger-select input at 1 and the channel enabled and idle, a one-cycle pulse on `sw_req_set` sets `sw_req_bit` on the next clock. That bit starts a transfer, and it reads 0 again once the transfer has been accepted.
- R2: With the trigger-select input at 0, a one-cycle `hw_req` pulse while enabled and idle starts a transfer.
- R3: After reset the bus is idle (`bus_req`, `bus_rd` and `bus_wr` are 0). A started transfer raises `bus_req` and waits for `bus_grant`. After the grant it performs exactly one read cycle (`bus_rd`), then one write cycle (`bus_wr`), then one dummy cycle with `bus_req` high and neither strobe. On the cycle after the dummy cycle, `bus_req` is 0.
- R4: On the first transfer after `ch_en` rises, `count` is loaded from `reload_cnt` and `fwd_ptr` is loaded from its base before the move. The base is `src_addr` in mode 00 and mode 1x, and `dst_addr` in mode 01.
- R5: After each transfer, `count` drops by 1. In the incrementing modes, `fwd_ptr` grows by 1 for 8-bit units and by 2 for 16-bit units (`unit16`=1).
- R6: A reload value N gives N+1 transfers. The transfer that finds `count` at 0 leaves `count` at all ones and sets `irq_flag` at that same clock edge. The channel keeps serving requests afterwards.
- R7: The first request after an underflow reloads `count` and `fwd_ptr` before it moves data.
- R8: `irq_flag` clears on the clock after a pulse on `irq_ack` or on `irq_clr`. A new underflow in the same cycle wins over the clear.
- R9: The address mode sets the bus addresses. In mode 00 the read address is `fwd_ptr` and the write address is `dst_addr`. In mode 01 the read address is `src_addr` and the write address is `fwd_ptr`. In modes 10 and 11 the read address is `src_addr` and the write address is `dst_addr` on every transfer.
- R10: Requests are ignored while `ch_en` is 0 and while a transfer is in progress. An ignored request produces no bus cycle, no counter change and no set `sw_req_bit`.
- R11: The data written is the data read in that transfer. In 8-bit mode only the low byte is passed on and the upper bits of `bus_wdata` are 0. `bus_wide` mirrors `unit16`.
- R12: The forward pointer wraps at the bus address width. For example, 8-bit steps from FFFFh go to 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 1 | Channel enable |
| sw_trig_sel | input | 1 | 1 selects the software request bit as trigger, 0 selects `hw_req` |
| sw_req_set | input | 1 | Write strobe setting the software request bit |
| hw_req | input | 1 | Hardware request pulse |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| irq_clr | input | 1 | Software clear of the interrupt flag |
| addr_mode | input | 2 | 00 increment source, 01 increment destination, 1x both fixed |
| unit16 | input | 1 | 1 for 16-bit units, 0 for 8-bit units |
| src_addr | input | AW | Source address |
| dst_addr | input | AW | Destination address |
| reload_cnt | input | CW | Transfer count reload value |
| bus_grant | input | 1 | Bus grant for the channel |
| bus_rdata | input | DW | Read data, valid during the read cycle |
| bus_req | output | 1 | Channel owns or requests the bus |
| bus_rd | output | 1 | Read cycle strobe |
| bus_wr | output | 1 | Write cycle strobe |
| bus_wide | output | 1 | Unit size of the current access |
| bus_addr | output | AW | Bus address during read and write cycles, 0 otherwise |
| bus_wdata | output | DW | Write data |
| sw_req_bit | output | 1 | Software request bit |
| irq_flag | output | 1 | Interrupt request flag |
| count | output | CW | Working transfer counter |
| fwd_ptr | output | AW | Working forward address pointer |

## Verification
The case hardest to reach from the ports is a request that arrives while a transfer is already under way. The bench holds `bus_grant` low so the channel stays in its bus-request state for several cycles, fires a second hardware request there, then releases the grant. It confirms that only one read/write pair happened and that the counter moved once. The underflow-and-reload path is reached with a reload value of 1, so the rollover to all ones and the restart from the base address both come within three requests.

// File: rtl/dmarep_pkg.sv
package dmarep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_DUM  = 3'd4
    } xfer_st_e;

    typedef enum logic [1:0] {
        AM_INC_SRC = 2'b00,
        AM_INC_DST = 2'b01,
        AM_FIXED   = 2'b10,
        AM_FIXED_B = 2'b11
    } amode_e;

endpackage

// File: rtl/dmarep_fsm.sv
module dmarep_fsm
    import dmarep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic grant,
    output logic bus_req,
    output logic rd_phase,
    output logic wr_phase,
    output logic accept,
    output logic done,
    output logic busy
);

    typedef struct packed {
        xfer_st_e st;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: if (start) fsm_d.st = ST_REQ;
            ST_REQ:  if (grant) fsm_d.st = ST_RD;
            ST_RD:   fsm_d.st = ST_WR;
            ST_WR:   fsm_d.st = ST_DUM;
            ST_DUM:  fsm_d.st = ST_IDLE;
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q.st <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    assign busy     = (fsm_q.st != ST_IDLE);
    assign bus_req  = busy;
    assign rd_phase = (fsm_q.st == ST_RD);
    assign wr_phase = (fsm_q.st == ST_WR);
    assign done     = (fsm_q.st == ST_DUM);
    assign accept   = (fsm_q.st == ST_IDLE) && start;

    assert_rd_then_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase |=> wr_phase);
    assert_wr_then_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> (bus_req && !rd_phase && !wr_phase));
    assert_dummy_releases_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !bus_req);
    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_phase, wr_phase}));

endmodule

// File: rtl/dmarep_req.sv
module dmarep_req (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sw_sel,
    input  logic sw_set,
    input  logic hw_req,
    input  logic busy,
    input  logic accept,
    input  logic underflow,
    input  logic irq_ack,
    input  logic irq_clr,
    output logic start,
    output logic sw_bit,
    output logic irq
);

    typedef struct packed {
        logic sw;
        logic irq;
    } req_s;

    req_s req_d, req_q;

    always_comb begin
        req_d = req_q;
        if (!en) begin
            req_d.sw = 1'b0;
        end else if (accept) begin
            req_d.sw = 1'b0;
        end else if (sw_set && sw_sel && !busy) begin
            req_d.sw = 1'b1;
        end

        if (underflow) begin
            req_d.irq = 1'b1;
        end else if (irq_ack || irq_clr) begin
            req_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q.sw  <= 1'b0;
            req_q.irq <= 1'b0;
        end else begin
            req_q <= req_d;
        end
    end

    assign start  = en && !busy && (sw_sel ? req_q.sw : hw_req);
    assign sw_bit = req_q.sw;
    assign irq    = req_q.irq;

    assert_sw_bit_cleared_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !sw_bit);
    assert_underflow_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> irq);
    assert_ack_clears_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_ack || irq_clr) && !underflow) |=> !irq);
    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !accept);

endmodule

// File: rtl/dmarep_dp.sv
module dmarep_dp
    import dmarep_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          accept,
    input  logic          rd_phase,
    input  logic          wr_phase,
    input  logic          done,
    input  logic [1:0]    mode,
    input  logic          unit16,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [CW-1:0] reload,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt,
    output logic [AW-1:0] fwd,
    output logic          underflow
);

    localparam int PADW = DW - 8;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] fwd;
        logic [DW-1:0] data;
        logic          pend;
        logic          en_prev;
    } dp_s;

    dp_s     dp_d, dp_q;
    amode_e  am;
    logic    en_rise;
    logic    reload_now;
    logic    inc_mode;
    logic [AW-1:0] base;
    logic [AW-1:0] step;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;

    assign am       = amode_e'(mode);
    assign inc_mode = (am == AM_INC_SRC) || (am == AM_INC_DST);
    assign base     = (am == AM_INC_DST) ? dst : src;
    assign step     = unit16 ? AW'(2) : AW'(1);
    assign rd_addr  = (am == AM_INC_SRC) ? dp_q.fwd : src;
    assign wr_addr  = (am == AM_INC_DST) ? dp_q.fwd : dst;

    always_comb begin
        dp_d         = dp_q;
        dp_d.en_prev = en;
        en_rise      = en && !dp_q.en_prev;
        reload_now   = dp_q.pend || en_rise;
        if (en_rise) dp_d.pend = 1'b1;

        if (accept) begin
            if (reload_now) begin
                dp_d.cnt = reload;
                dp_d.fwd = base;
            end
            dp_d.pend = 1'b0;
        end

        if (rd_phase) begin
            dp_d.data = unit16 ? rdata : {{PADW{1'b0}}, rdata[7:0]};
        end

        if (done) begin
            dp_d.cnt = dp_q.cnt - CW'(1);
            if (inc_mode) dp_d.fwd = dp_q.fwd + step;
            if (dp_q.cnt == '0) dp_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q.cnt     <= '0;
            dp_q.fwd     <= '0;
            dp_q.data    <= '0;
            dp_q.pend    <= 1'b1;
            dp_q.en_prev <= 1'b0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign bus_addr  = rd_phase ? rd_addr : (wr_phase ? wr_addr : '0);
    assign wdata     = dp_q.data;
    assign cnt       = dp_q.cnt;
    assign fwd       = dp_q.fwd;
    assign underflow = done && (dp_q.cnt == '0);

    assert_reload_on_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && reload_now) |=> (cnt == $past(reload)));
    assert_count_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !underflow) |=> (cnt == $past(cnt) - CW'(1)));
    assert_underflow_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> (cnt == '1));
    assert_next_reloads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> dp_q.pend);
    assert_fixed_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !inc_mode) |=> (fwd == $past(fwd)));

endmodule

// File: rtl/dmarep_chan.sv
module dmarep_chan
    import dmarep_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_en,
    input  logic          sw_trig_sel,
    input  logic          sw_req_set,
    input  logic          hw_req,
    input  logic          irq_ack,
    input  logic          irq_clr,
    input  logic [1:0]    addr_mode,
    input  logic          unit16,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] reload_cnt,
    input  logic          bus_grant,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_wide,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          sw_req_bit,
    output logic          irq_flag,
    output logic [CW-1:0] count,
    output logic [AW-1:0] fwd_ptr
);

    logic start, accept, done, busy, underflow;

    dmarep_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .grant    (bus_grant),
        .bus_req  (bus_req),
        .rd_phase (bus_rd),
        .wr_phase (bus_wr),
        .accept   (accept),
        .done     (done),
        .busy     (busy)
    );

    dmarep_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ch_en),
        .sw_sel    (sw_trig_sel),
        .sw_set    (sw_req_set),
        .hw_req    (hw_req),
        .busy      (busy),
        .accept    (accept),
        .underflow (underflow),
        .irq_ack   (irq_ack),
        .irq_clr   (irq_clr),
        .start     (start),
        .sw_bit    (sw_req_bit),
        .irq       (irq_flag)
    );

    dmarep_dp #(
        .AW (AW),
        .CW (CW),
        .DW (DW)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ch_en),
        .accept    (accept),
        .rd_phase  (bus_rd),
        .wr_phase  (bus_wr),
        .done      (done),
        .mode      (addr_mode),
        .unit16    (unit16),
        .src       (src_addr),
        .dst       (dst_addr),
        .reload    (reload_cnt),
        .rdata     (bus_rdata),
        .bus_addr  (bus_addr),
        .wdata     (bus_wdata),
        .cnt       (count),
        .fwd       (fwd_ptr),
        .underflow (underflow)
    );

    assign bus_wide = unit16;

endmodule

// File: tb/dmarep_chan_tb.sv
`timescale 1ns/100ps
module dmarep_chan_tb;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ch_en = 1'b0, sw_trig_sel = 1'b0, sw_req_set = 1'b0, hw_req = 1'b0;
    logic          irq_ack = 1'b0, irq_clr = 1'b0, unit16 = 1'b0, bus_grant = 1'b1;
    logic [1:0]    addr_mode = 2'b00;
    logic [AW-1:0] src_addr = '0, dst_addr = '0;
    logic [CW-1:0] reload_cnt = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_req, bus_rd, bus_wr, bus_wide, sw_req_bit, irq_flag;
    logic [AW-1:0] bus_addr, fwd_ptr;
    logic [DW-1:0] bus_wdata;
    logic [CW-1:0] count;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int rd_cnt = 0, wr_cnt = 0, req_cnt = 0;
    logic [AW-1:0] last_rd, last_wr;
    logic [DW-1:0] last_wd;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign bus_rdata = bus_addr ^ 16'h5A3C;

    dmarep_chan #(.AW(AW), .CW(CW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .sw_trig_sel(sw_trig_sel),
        .sw_req_set(sw_req_set), .hw_req(hw_req), .irq_ack(irq_ack), .irq_clr(irq_clr),
        .addr_mode(addr_mode), .unit16(unit16), .src_addr(src_addr), .dst_addr(dst_addr),
        .reload_cnt(reload_cnt), .bus_grant(bus_grant), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sw_req_bit(sw_req_bit),
        .irq_flag(irq_flag), .count(count), .fwd_ptr(fwd_ptr)
    );

    always @(negedge clk) begin
        if (bus_rd) begin rd_cnt <= rd_cnt + 1; last_rd <= bus_addr; end
        if (bus_wr) begin wr_cnt <= wr_cnt + 1; last_wr <= bus_addr; last_wd <= bus_wdata; end
        if (bus_req) req_cnt <= req_cnt + 1;
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setup(input logic [1:0] m, input logic u16, input logic [AW-1:0] s,
                         input logic [AW-1:0] d, input logic [CW-1:0] r, input logic swsel);
        ch_en = 1'b0; irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        addr_mode = m; unit16 = u16; src_addr = s; dst_addr = d; reload_cnt = r;
        sw_trig_sel = swsel; bus_grant = 1'b1;
        ch_en = 1'b1; tick();
    endtask

    task automatic wait_idle();
        int lim = 0;
        while (!bus_req && lim < 40) begin tick(); lim++; end
        while (bus_req && lim < 80) begin tick(); lim++; end
        check(lim < 80, "R3 transfer completes", lim, 0);
    endtask

    task automatic xfer();
        if (sw_trig_sel) sw_req_set = 1'b1; else hw_req = 1'b1;
        tick();
        sw_req_set = 1'b0; hw_req = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        check(!bus_req && !bus_rd && !bus_wr, "R3 reset bus idle", bus_req, 0);
        check(!irq_flag, "R8 reset irq", irq_flag, 0);
        check(!sw_req_bit, "R1 reset sw bit", sw_req_bit, 0);
    endtask

    task automatic t_sw_inc_src();
        setup(2'b00, 1'b1, 16'h1000, 16'h2000, 8'd3, 1'b1);
        sw_req_set = 1'b1; tick(); sw_req_set = 1'b0;
        check(sw_req_bit, "R1 sw bit set", sw_req_bit, 1);
        tick();
        check(!sw_req_bit, "R1 sw bit cleared on accept", sw_req_bit, 0);
        wait_idle();
        check(last_rd == 16'h1000, "R9 inc-src read addr", last_rd, 16'h1000);
        check(last_wr == 16'h2000, "R9 inc-src write addr", last_wr, 16'h2000);
        check(last_wd == 16'h4A3C, "R11 16-bit data", last_wd, 16'h4A3C);
        check(bus_wide, "R11 bus_wide", bus_wide, 1);
        check(count == 8'd2, "R4 R5 count after first", count, 2);
        check(fwd_ptr == 16'h1002, "R5 fwd step 2", fwd_ptr, 16'h1002);
        xfer();
        check(last_rd == 16'h1002, "R5 second read addr", last_rd, 16'h1002);
        check(count == 8'd1, "R5 count after second", count, 1);
        // re-enable forces reload
        ch_en = 1'b0; tick(); ch_en = 1'b1; tick();
        xfer();
        check(last_rd == 16'h1000, "R4 reload after re-enable", last_rd, 16'h1000);
        check(count == 8'd2, "R4 count after re-enable", count, 2);
    endtask

    task automatic t_bus_seq_busy();
        int wr0, lim;
        setup(2'b00, 1'b1, 16'h0A00, 16'h0B00, 8'd7, 1'b0);
        bus_grant = 1'b0;
        hw_req = 1'b1; tick(); hw_req = 1'b0;
        wr0 = wr_cnt;
        tick(); tick();
        check(bus_req, "R2 hw request raises bus_req", bus_req, 1);
        hw_req = 1'b1; tick(); hw_req = 1'b0;  // R10 request while busy
        tick();
        check(rd_cnt == 0 || !bus_rd, "R3 no read before grant", bus_rd, 0);
        bus_grant = 1'b1;
        lim = 0;
        while (!bus_rd && lim < 10) begin tick(); lim++; end
        check(bus_rd && !bus_wr, "R3 read cycle", bus_rd, 1);
        tick();
        check(bus_wr && !bus_rd, "R3 write cycle", bus_wr, 1);
        tick();
        check(bus_req && !bus_rd && !bus_wr, "R3 dummy cycle", bus_req, 1);
        tick();
        check(!bus_req, "R3 bus released", bus_req, 0);
        repeat (6) tick();
        check(wr_cnt == wr0 + 1, "R10 busy request ignored", wr_cnt - wr0, 1);
        check(count == 8'd6, "R10 count moved once", count, 6);
    endtask

    task automatic t_underflow();
        setup(2'b00, 1'b0, 16'h0300, 16'h0400, 8'd1, 1'b1);
        xfer();
        check(count == 8'd0 && !irq_flag, "R6 count 0 no irq", count, 0);
        check(last_wd == 16'h003C, "R11 8-bit low byte", last_wd, 16'h003C);
        check(fwd_ptr == 16'h0301, "R5 fwd step 1", fwd_ptr, 16'h0301);
        xfer();
        check(count == 8'hFF, "R6 underflow count", count, 8'hFF);
        check(irq_flag, "R6 irq on underflow", irq_flag, 1);
        xfer();
        check(last_rd == 16'h0300, "R7 reload pointer", last_rd, 16'h0300);
        check(count == 8'd0, "R7 reload count", count, 0);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        check(!irq_flag, "R8 ack clears irq", irq_flag, 1);
        xfer();
        check(irq_flag, "R6 second underflow", irq_flag, 1);
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
        check(!irq_flag, "R8 sw clear", irq_flag, 1);
    endtask

    task automatic t_inc_dst();
        setup(2'b01, 1'b1, 16'h0500, 16'h0600, 8'd5, 1'b0);
        xfer();
        check(last_rd == 16'h0500 && last_wr == 16'h0600, "R9 inc-dst first", last_wr, 16'h0600);
        xfer();
        check(last_rd == 16'h0500, "R9 inc-dst fixed read", last_rd, 16'h0500);
        check(last_wr == 16'h0602, "R9 inc-dst write step", last_wr, 16'h0602);
        check(fwd_ptr == 16'h0604, "R4 fwd from dst", fwd_ptr, 16'h0604);
    endtask

    task automatic t_fixed();
        setup(2'b10, 1'b0, 16'h0700, 16'h0800, 8'd2, 1'b1);
        for (int i = 0; i < 3; i++) begin
            xfer();
            check(last_rd == 16'h0700 && last_wr == 16'h0800, "R9 fixed addrs", last_rd, 16'h0700);
        end
        check(count == 8'hFF && irq_flag, "R6 N+1 transfers fixed", count, 8'hFF);
    endtask

    task automatic t_wrap();
        setup(2'b00, 1'b0, 16'hFFFF, 16'h0100, 8'd4, 1'b0);
        xfer();
        check(last_rd == 16'hFFFF, "R12 read at top", last_rd, 16'hFFFF);
        xfer();
        check(last_rd == 16'h0000, "R12 wrap to zero", last_rd, 16'h0000);
        check(fwd_ptr == 16'h0001, "R12 fwd after wrap", fwd_ptr, 16'h0001);
        setup(2'b00, 1'b1, 16'hFFFE, 16'h0100, 8'd4, 1'b0);
        xfer();
        check(fwd_ptr == 16'h0000, "R12 16-bit wrap", fwd_ptr, 16'h0000);
    endtask

    task automatic t_disabled();
        int rq0;
        setup(2'b00, 1'b0, 16'h0900, 16'h0A00, 8'd3, 1'b1);
        ch_en = 1'b0; tick();
        rq0 = req_cnt;
        sw_req_set = 1'b1; hw_req = 1'b1; tick(); sw_req_set = 1'b0; hw_req = 1'b0;
        check(!sw_req_bit, "R10 sw bit not set when disabled", sw_req_bit, 0);
        sw_trig_sel = 1'b0; hw_req = 1'b1; tick(); hw_req = 1'b0;
        repeat (8) tick();
        check(req_cnt == rq0, "R10 no bus activity when disabled", req_cnt - rq0, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sw_inc_src();
        t_bus_seq_busy();
        t_underflow();
        t_inc_dst();
        t_fixed();
        t_wrap();
        t_disabled();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        wait (cyc >= 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<20000", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule